// File: doc/BRIEF.md
# Swapped-Address Flash Byte Programmer

This block drives a cartridge-style address generator to store one byte into a parallel flash. The generator has two parts. An 8-bit shift register holds connector address bits 11 to 18. An 11-bit ripple counter holds connector bits 0 to 10. Every shift pulse clears the counter, and every count strobe advances it by one. The flash address lines are wired to the connector in a permuted order, chosen so that the three-write unlock preamble needs very few counter steps.

The sequencer takes a flash address and a data byte over a ready/valid handshake. It issues the shift pulses, count strobes and write strobes for the three unlock writes and then for the destination write. Each shift clears the counter, so for every write the page bits are loaded first and the counter is stepped afterwards. The destination connector address is found by inverting the permutation. A byte of 0xFF is left unwritten, because an erased flash already holds that value.

By default the top connector counter bit is not used. In its place a separate output carries flash address bit 18, which roughly halves the average number of counter steps for the destination.

Top module: `swz_flash_prog`

## Requirements
- R1: After a synchronous active-low reset, `in_ready` is 1, and `shift_clk`, `cnt_strobe`, `wr_strobe`, `aux_bit10` and `done` are all 0.
- R2: A byte is accepted only in the idle state. From the cycle after acceptance until `done`, `in_ready` is 0, and any address or data offered during that time has no effect on the writes.
- R3: Connector model used for the address. On a rising `shift_clk`, `shift_dat` enters connector bit 11, bits 11..17 move up to 12..18, and the counter is cleared. On a rising `cnt_strobe`, the counter (connector bits 0..10) increments.
- R4: Flash address mapping. Flash bit i (i = 0..7) equals connector bit 18-i. Flash bits 8, 10, 12 and 14 come from connector bits 0 to 3. Flash bits 9, 11 and 13 come from connector bits 4 to 6. Flash bits 15, 16 and 17 come from connector bits 7, 8 and 9. Flash bit 18 comes from `aux_bit10`.
- R5: A non-0xFF byte produces exactly four writes, in this order: 0xAA to flash 0x5555, 0x55 to 0x2AAA, 0xA0 to 0x5555, and then the data to the requested address.
- R6: The four writes of a byte use 8, 1, 1 and 8 shift pulses in that order, 18 in total.
- R7: The three unlock writes use 15, 112 and 15 count strobes. The destination write uses as many count strobes as its counter offset, so a byte uses 142 plus the offset in total.
- R8: The destination offset is never above 1023. Flash bit 18 is carried on `aux_bit10`, which is 0 whenever `shift_clk` is high and 0 during the unlock writes.
- R9: A byte of 0xFF causes no strobe of any kind, and `done` is raised on the cycle after acceptance.
- R10: `done` is a one-cycle pulse. It is raised after the last write strobe of a byte has ended.
- R11: At most one of the three strobes is high at a time. Each strobe pulse is high for exactly PULSE_CYC cycles. `shift_dat` and `wr_data` stay stable while their strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A byte request is offered |
| in_ready | output | 1 | Sequencer is idle and takes a request |
| in_addr | input | 19 | Target flash address |
| in_data | input | 8 | Byte to store |
| shift_clk | output | 1 | Shift pulse to the page shift register (clears the counter) |
| shift_dat | output | 1 | Bit entering the shift register |
| cnt_strobe | output | 1 | Count strobe that advances the offset counter |
| wr_strobe | output | 1 | Flash write strobe |
| wr_data | output | 8 | Data presented to the flash during a write |
| aux_bit10 | output | 1 | Separate line carrying flash address bit 18 |
| done | output | 1 | One-cycle pulse when a byte is finished or skipped |

## Verification
The assertions assume that `in_addr` and `in_data` are sampled only on the accepting edge. They also assume that the external address generator does nothing except follow the three strobes. The stimulus holds the request for one cycle while `in_ready` is high. In selected transactions it then keeps `in_valid` high with different values while the block is busy, but only until `done` is seen, so the idle state never picks up a stray request. Random addresses cover the whole 19-bit range. Directed addresses reach an offset of zero, offsets of 1023 and 1024, and the all-ones address.

// File: rtl/fsp_pkg.sv
// Shared constants and types for the swapped-address flash programmer.
// Assumes a 19-bit flash address, an 8-bit shift register for connector
// bits 11..18 and an 11-bit counter for connector bits 0..10.
package fsp_pkg;
    localparam int FA_W   = 19;   // flash address width
    localparam int PAGE_W = 8;    // shift register length
    localparam int CNT_W  = 11;   // connector counter width
    localparam int DAT_W  = 8;    // flash data width

    localparam logic [FA_W-1:0]  UNLOCK_A = 19'h05555;
    localparam logic [FA_W-1:0]  UNLOCK_B = 19'h02AAA;
    localparam logic [DAT_W-1:0] CMD_1    = 8'hAA;
    localparam logic [DAT_W-1:0] CMD_2    = 8'h55;
    localparam logic [DAT_W-1:0] CMD_3    = 8'hA0;
    localparam logic [DAT_W-1:0] ERASED   = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_COUNT,
        ST_WRITE,
        ST_DONE
    } fsp_state_t;
endpackage

// File: rtl/fsp_strobe_timer.sv
// Strobe timer: while go is held, produces repeated pulses that are high
// for PULSE_CYC cycles and then low for PULSE_CYC cycles. fin marks the
// last cycle of each pulse period. Assumes go may drop only on fin.
module fsp_strobe_timer #(
    parameter int PULSE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic level,
    output logic fin
);
    localparam int PERIOD = 2 * PULSE_CYC;
    localparam int TW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic          active;
    logic [TW-1:0] tcnt;

    // Period counter: start on go, stop after the last period cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            tcnt   <= '0;
        end else if (!active) begin
            active <= go;
            tcnt   <= '0;
        end else if (fin) begin
            active <= 1'b0;
            tcnt   <= '0;
        end else begin
            tcnt <= tcnt + TW'(1);
        end
    end

    // High half and end-of-period decode.
    always_comb begin
        level = active && (tcnt < TW'(PULSE_CYC));
        fin   = active && (tcnt == TW'(PERIOD - 1));
    end

    // R11: a period ends with the strobe low.
    p_fin_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> !level);
endmodule

// File: rtl/fsp_addr_map.sv
// Address mapper: turns a flash address into the bit to shift next and
// into the counter goal, by inverting the connector-to-flash permutation.
// When AUX_EN is set, flash bit 18 leaves the counter field and goes to a
// separate output, so the goal fits in 10 bits.
module fsp_addr_map
    import fsp_pkg::*;
#(
    parameter bit AUX_EN = 1'b1
) (
    input  logic [FA_W-1:0]  tgt,
    input  logic [2:0]       idx,
    input  logic             full_load,
    output logic             shift_bit,
    output logic [CNT_W-1:0] cnt_goal,
    output logic             aux_val
);
    logic [CNT_W-1:0] field;

    // Counter field of the target, connector bit 10 down to bit 0.
    always_comb begin
        field = {tgt[18], tgt[17], tgt[16], tgt[15],
                 tgt[13], tgt[11], tgt[9],
                 tgt[14], tgt[12], tgt[10], tgt[8]};
        // Full load: k-th bit shifted ends at connector 18-k = flash bit k.
        // Single shift: new connector bit 11 = flash bit 7.
        shift_bit = full_load ? tgt[idx] : tgt[7];
    end

    generate
        if (AUX_EN) begin : g_aux
            // Top counter bit moves to the side line.
            always_comb begin
                cnt_goal = {1'b0, field[CNT_W-2:0]};
                aux_val  = field[CNT_W-1];
            end
        end else begin : g_plain
            // Whole field is counted.
            always_comb begin
                cnt_goal = field;
                aux_val  = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/swz_flash_prog.sv
// Swapped-address flash byte programmer. For each accepted non-0xFF byte it
// runs three unlock writes and one destination write. Each write loads the
// page bits by shifting, steps the counter up to the offset, then strobes
// the write line. Assumes the external counter is cleared by every shift
// and advanced by every count strobe.
module swz_flash_prog
    import fsp_pkg::*;
#(
    parameter int PULSE_CYC = 2,
    parameter bit AUX_EN    = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [FA_W-1:0]  in_addr,
    input  logic [DAT_W-1:0] in_data,
    output logic             shift_clk,
    output logic             shift_dat,
    output logic             cnt_strobe,
    output logic             wr_strobe,
    output logic [DAT_W-1:0] wr_data,
    output logic             aux_bit10,
    output logic             done
);
    fsp_state_t       state;
    logic [1:0]       phase;       // 0..2 unlock writes, 3 destination
    logic [2:0]       sh_idx;
    logic [CNT_W-1:0] cnt_done;
    logic [FA_W-1:0]  dest_addr;
    logic [DAT_W-1:0] dest_data;

    logic [FA_W-1:0]  tgt;
    logic             full_load;
    logic             last_shift;
    logic             go, level, fin;
    logic             sbit, aux_val;
    logic [CNT_W-1:0] cnt_goal;

    // Target address and write data of the current phase.
    always_comb begin
        case (phase)
            2'd0:    begin tgt = UNLOCK_A;  wr_data = CMD_1;     end
            2'd1:    begin tgt = UNLOCK_B;  wr_data = CMD_2;     end
            2'd2:    begin tgt = UNLOCK_A;  wr_data = CMD_3;     end
            default: begin tgt = dest_addr; wr_data = dest_data; end
        endcase
        full_load  = (phase == 2'd0) || (phase == 2'd3);
        last_shift = full_load ? (sh_idx == 3'd7) : 1'b1;
    end

    fsp_addr_map #(.AUX_EN(AUX_EN)) u_map (
        .tgt      (tgt),
        .idx      (sh_idx),
        .full_load(full_load),
        .shift_bit(sbit),
        .cnt_goal (cnt_goal),
        .aux_val  (aux_val)
    );

    fsp_strobe_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (go),
        .level(level),
        .fin  (fin)
    );

    // Output decode: route the timer pulse to the line of the current step.
    always_comb begin
        go         = (state == ST_SHIFT) || (state == ST_COUNT) || (state == ST_WRITE);
        in_ready   = (state == ST_IDLE);
        done       = (state == ST_DONE);
        shift_clk  = level && (state == ST_SHIFT);
        cnt_strobe = level && (state == ST_COUNT);
        wr_strobe  = level && (state == ST_WRITE);
        shift_dat  = sbit;
        aux_bit10  = (phase == 2'd3) && aux_val &&
                     ((state == ST_COUNT) || (state == ST_WRITE));
    end

    // Sequencer: accept, shift page bits, count the offset, write, repeat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase     <= 2'd0;
            sh_idx    <= 3'd0;
            cnt_done  <= '0;
            dest_addr <= '0;
            dest_data <= '0;
        end else begin
            case (state)
                ST_IDLE: if (in_valid) begin
                    dest_addr <= in_addr;
                    dest_data <= in_data;
                    phase     <= 2'd0;
                    sh_idx    <= 3'd0;
                    state     <= (in_data == ERASED) ? ST_DONE : ST_SHIFT;
                end
                ST_SHIFT: if (fin) begin
                    if (last_shift) begin
                        sh_idx   <= 3'd0;
                        cnt_done <= '0;
                        state    <= (cnt_goal == '0) ? ST_WRITE : ST_COUNT;
                    end else begin
                        sh_idx <= sh_idx + 3'd1;
                    end
                end
                ST_COUNT: if (fin) begin
                    cnt_done <= cnt_done + CNT_W'(1);
                    if (cnt_done + CNT_W'(1) == cnt_goal) state <= ST_WRITE;
                end
                ST_WRITE: if (fin) begin
                    if (phase == 2'd3) begin
                        state <= ST_DONE;
                    end else begin
                        phase <= phase + 2'd1;
                        state <= ST_SHIFT;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R11: strobes never overlap.
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shift_clk, cnt_strobe, wr_strobe}));
    // R11: data lines hold while their strobe is high.
    p_wdat_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && $past(wr_strobe)) |-> $stable(wr_data));
    p_sdat_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_clk && $past(shift_clk)) |-> $stable(shift_dat));
    // R8: the side line is low whenever the shift register is clocked.
    p_aux_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shift_clk |-> !aux_bit10);
    // R10: done lasts one cycle.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2: no acceptance while busy.
    p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
    // R9: an erased-value byte goes straight to done.
    p_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_data == ERASED) |=>
        (done && !shift_clk && !cnt_strobe && !wr_strobe));
    // R7: the counter is never stepped past its goal.
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT) |-> (cnt_done < cnt_goal));
endmodule

// File: tb/swz_flash_prog_tb.sv
// Bench: models the connector shift register, counter and address
// permutation, records every flash write and compares against the
// requirements.
module swz_flash_prog_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PULSE_CYC  = 2;
    localparam int TX_LIMIT   = 12000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [18:0] in_addr = '0;
    logic [7:0]  in_data = '0;
    logic        shift_clk, shift_dat, cnt_strobe, wr_strobe, aux_bit10, done;
    logic [7:0]  wr_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    swz_flash_prog #(.PULSE_CYC(PULSE_CYC), .AUX_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_data(in_data), .shift_clk(shift_clk),
        .shift_dat(shift_dat), .cnt_strobe(cnt_strobe), .wr_strobe(wr_strobe),
        .wr_data(wr_data), .aux_bit10(aux_bit10), .done(done)
    );

    // Connector model state and per-transaction logs.
    logic [7:0]  sreg = '0;       // sreg[0] = connector 11, sreg[7] = connector 18
    int          mcnt = 0;
    int          m_shifts = 0, m_counts = 0, nwr = 0;
    int          sh_per[0:3];
    int          cn_per[0:3];
    logic [18:0] wlog_a[0:3];
    logic [7:0]  wlog_d[0:3];
    int          wr_cnt_at = 0;
    logic        wr_aux_at = 1'b0;
    int          err_width = 0, err_stab = 0, err_ovl = 0, err_aux = 0;
    logic        p_sh = 0, p_cn = 0, p_wr = 0, p_any = 0;
    logic        sv_s = 0;
    logic [7:0]  sv_w = '0;
    int          run = 0;

    // R4: flash address from connector state.
    function automatic logic [18:0] flash_of(logic [7:0] s, int c, logic aux);
        logic [18:0] f;
        logic [10:0] cb;
        cb = c[10:0];
        for (int i = 0; i < 8; i++) f[i] = s[7-i];
        f[8]  = cb[0]; f[10] = cb[1]; f[12] = cb[2]; f[14] = cb[3];
        f[9]  = cb[4]; f[11] = cb[5]; f[13] = cb[6];
        f[15] = cb[7]; f[16] = cb[8]; f[17] = cb[9];
        f[18] = aux;
        return f;
    endfunction

    // Expected counter offset (bits 9..0) and side bit (bit 10) for an address.
    function automatic logic [10:0] exp_off(logic [18:0] a);
        return {a[18], a[17], a[16], a[15], a[13], a[11], a[9], a[14], a[12], a[10], a[8]};
    endfunction

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (shift_clk && !p_sh) begin
                if (aux_bit10) err_aux++;
                sreg = {sreg[6:0], shift_dat};
                mcnt = 0;
                m_shifts++;
                if (nwr < 4) sh_per[nwr]++;
                sv_s = shift_dat;
            end else if (shift_clk && shift_dat != sv_s) err_stab++;
            if (cnt_strobe && !p_cn) begin
                mcnt++;
                m_counts++;
                if (nwr < 4) cn_per[nwr]++;
            end
            if (wr_strobe && !p_wr) begin
                if (nwr < 4) begin
                    wlog_a[nwr] = flash_of(sreg, mcnt, aux_bit10);
                    wlog_d[nwr] = wr_data;
                end
                wr_cnt_at = mcnt;
                wr_aux_at = aux_bit10;
                nwr++;
                sv_w = wr_data;
            end else if (wr_strobe && wr_data != sv_w) err_stab++;
            if ((int'(shift_clk) + int'(cnt_strobe) + int'(wr_strobe)) > 1) err_ovl++;
            if (shift_clk || cnt_strobe || wr_strobe) run++;
            else if (p_any) begin
                if (run != PULSE_CYC) err_width++;
                run = 0;
            end
            p_sh = shift_clk; p_cn = cnt_strobe; p_wr = wr_strobe;
            p_any = shift_clk || cnt_strobe || wr_strobe;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        m_shifts = 0; m_counts = 0; nwr = 0;
        err_width = 0; err_stab = 0; err_ovl = 0; err_aux = 0;
        for (int i = 0; i < 4; i++) begin sh_per[i] = 0; cn_per[i] = 0; end
    endtask

    // One byte request; noise keeps offering other values while busy.
    task automatic run_tx(input logic [18:0] a, input logic [7:0] d, input bit noise);
        int w;
        bit seen;
        logic [10:0] off;
        clear_logs();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_data = d;
        @(negedge clk);
        if (noise) begin
            in_addr = a ^ 19'h3C3C3; in_data = d ^ 8'h5A;
            chk(in_ready == 1'b0, "R2", "ready while busy", in_ready, 0);
        end else begin
            in_valid = 1'b0;
        end
        w = 0; seen = 0;
        while (!seen && w < TX_LIMIT) begin
            if (done) seen = 1;
            else begin @(negedge clk); w++; end
        end
        in_valid = 1'b0;
        chk(seen, "R10", "done seen", seen, 1);
        if (!seen) return;
        off = exp_off(a);
        if (d == 8'hFF) begin
            chk(w == 0, "R9", "done latency", w, 0);
            chk(m_shifts == 0 && m_counts == 0 && nwr == 0, "R9", "strobes on skip",
                m_shifts + m_counts + nwr, 0);
        end else begin
            chk(nwr == 4, "R5", "write count", nwr, 4);
            chk(wlog_a[0] == 19'h05555 && wlog_d[0] == 8'hAA, "R5", "unlock 1",
                {wlog_a[0], wlog_d[0]}, {19'h05555, 8'hAA});
            chk(wlog_a[1] == 19'h02AAA && wlog_d[1] == 8'h55, "R5", "unlock 2",
                {wlog_a[1], wlog_d[1]}, {19'h02AAA, 8'h55});
            chk(wlog_a[2] == 19'h05555 && wlog_d[2] == 8'hA0, "R5", "unlock 3",
                {wlog_a[2], wlog_d[2]}, {19'h05555, 8'hA0});
            chk(wlog_a[3] == a && wlog_d[3] == d, "R5 R2", "destination write",
                {wlog_a[3], wlog_d[3]}, {a, d});
            chk(sh_per[0] == 8 && sh_per[1] == 1 && sh_per[2] == 1 && sh_per[3] == 8,
                "R6 R3", "shifts per write", m_shifts, 18);
            chk(cn_per[0] == 15 && cn_per[1] == 112 && cn_per[2] == 15 &&
                cn_per[3] == int'(off[9:0]), "R7", "counts total",
                m_counts, 142 + int'(off[9:0]));
            chk(wr_cnt_at <= 1023 && wr_aux_at == off[10], "R8", "offset/side bit",
                {wr_aux_at, 21'(wr_cnt_at)}, {off[10], 21'(off[9:0])});
            chk(err_aux == 0, "R8", "side bit high at shift", err_aux, 0);
            chk(err_width == 0 && err_ovl == 0 && err_stab == 0, "R11", "strobe shape",
                err_width + err_ovl + err_stab, 0);
        end
        @(negedge clk);
        chk(done == 1'b0, "R10", "done width", done, 0);
    endtask

    // Hard watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait (cyc >= 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected < 190000 cycles", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [18:0] ra;
        logic [7:0]  rd;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
        chk({shift_clk, cnt_strobe, wr_strobe} == 3'b000, "R1", "strobes after reset",
            {shift_clk, cnt_strobe, wr_strobe}, 0);
        chk(done == 1'b0 && aux_bit10 == 1'b0, "R1", "done/side after reset",
            {done, aux_bit10}, 0);
        // Directed corners (R3 R4 model in every write check)
        run_tx(19'h00000, 8'h3C, 1'b0);   // zero offset
        run_tx(19'h7FFFF, 8'h00, 1'b0);   // all ones
        run_tx(19'h40000, 8'h81, 1'b0);   // offset 1024: side bit only
        run_tx(19'h3FF00, 8'h7E, 1'b0);   // offset 1023
        run_tx(19'h12345, 8'hFF, 1'b0);   // skipped byte
        run_tx(19'h0A5A5, 8'h5A, 1'b1);   // inputs ignored while busy
        run_tx(19'h2BCDE, 8'hFF, 1'b1);   // skipped, with noise
        // Random requests
        for (int k = 0; k < 18; k++) begin
            ra = 19'($urandom);
            rd = ($urandom_range(0, 5) == 0) ? 8'hFF : 8'($urandom);
            run_tx(ra, rd, ($urandom_range(0, 3) == 0));
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule